// File: doc/BRIEF.md
# Dual-Port I/O Mailbox with Host Wait

This block holds a pair of 8-bit mailbox registers, an address slot and a data slot, shared by two unrelated buses. The card host bus is asynchronous: a host I/O cycle is marked by register-select low, card-enable-1 low and card-enable-2 high (an 8-bit access on the low byte), and it moves data with separate I/O read and I/O write strobes. The DSP bus is synchronous to the DSP clock. The DSP reaches the same two registers through its own address bus, qualified by an active-low I/O-memory select together with its read or write strobe.

The host strobes pass through a two-flop synchronizer into the DSP clock domain. A small host-side state machine then sequences each host cycle. Its states are H_IDLE, H_WDONE (write committed, waiting for the strobe to end), H_RWAIT (read held off) and H_RSERVE (read data captured and presented). The transitions are these. H_IDLE goes to H_WDONE on a synchronized write. H_IDLE goes to H_RWAIT on a synchronized read while a DSP write is active, and to H_RSERVE on a synchronized read with no DSP write. H_RWAIT goes to H_RSERVE once the DSP write ends. H_WDONE and H_RSERVE go back to H_IDLE when their synchronized strobe drops. While the machine sits in H_RWAIT, the active-low wait output stretches the host cycle. Either side reads back what the other wrote.

Top module: `io_mailbox`

## Requirements
- R1: After reset both registers read 0, host_wait_n is 1, and host_rd_oe and dsp_rd_oe are 0.
- R2: A host cycle is recognized only with host_reg_n=0, host_ce1_n=0 and host_ce2_n=1. A host write with host_ce2_n=0 or host_reg_n=1 leaves both registers unchanged.
- R3: A host write to host address 0x6 (address slot) or 0x7 (data slot) is read back by the DSP at DSP address 0x40 or 0x41 respectively.
- R4: A DSP write (dsp_ms_n=0, dsp_wr_n=0) to 0x40 or 0x41 is read back by the host at 0x6 or 0x7 respectively.
- R5: host_rd_oe is 1 only while a qualified host read strobe is active, and dsp_rd_oe is 1 only while dsp_ms_n=0 and dsp_rd_n=0. Each side's read data is 0 while its enable is 0.
- R6: If a host read becomes active while a DSP write is active, host_wait_n goes to 0 and stays 0 until the DSP write ends. The host then receives the value the DSP wrote.
- R7: A host read with no DSP write active never drives host_wait_n to 0.
- R8: When a host write and a DSP write target the same register in the same cycle, the register holds the DSP value.
- R9: When a host write and a DSP write target different registers in the same cycle, both values are stored.
- R10: A host write takes effect at the third DSP clock rising edge after its qualified strobe becomes active, and not at the second.
- R11: Writes to any address other than the two register addresses are ignored on both buses, and DSP reads of such an address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DSP clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_reg_n | input | 1 | Host register/I-O space select, active low |
| host_ce1_n | input | 1 | Host card enable for the low byte, active low |
| host_ce2_n | input | 1 | Host card enable for the high byte, must be high |
| host_iord_n | input | 1 | Host I/O read strobe, active low |
| host_iowr_n | input | 1 | Host I/O write strobe, active low |
| host_addr | input | 4 | Host I/O address |
| host_wdata | input | 8 | Host write data (low byte) |
| host_rdata | output | 8 | Host read data, 0 when not enabled |
| host_rd_oe | output | 1 | Host read data output enable |
| host_wait_n | output | 1 | Active-low wait that stretches a host cycle |
| dsp_ms_n | input | 1 | DSP I/O-memory select, active low |
| dsp_rd_n | input | 1 | DSP read strobe, active low |
| dsp_wr_n | input | 1 | DSP write strobe, active low |
| dsp_addr | input | 8 | DSP address |
| dsp_wdata | input | 8 | DSP write data |
| dsp_rdata | output | 8 | DSP read data, 0 when not enabled |
| dsp_rd_oe | output | 1 | DSP read data output enable |

## Verification
Traffic is tried in each direction on both registers with distinct byte values, so that a swapped slot or a crossed data path shows up. Host reads are tried alone and overlapping a held DSP write. The first case tells a spurious wait apart from a correct one. The second shows whether wait holds for the whole DSP write and whether the host then gets the DSP value rather than the value from before the write. Simultaneous writes are tried to the same register and to different registers, which separates correct DSP priority from lost or blocked writes. Malformed host cycles, stray addresses and a sample one edge early on the host-write latency confirm that nothing lands where it should not or sooner than it should.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [1:0] {
        H_IDLE   = 2'd0,
        H_WDONE  = 2'd1,
        H_RWAIT  = 2'd2,
        H_RSERVE = 2'd3
    } host_st_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d_async;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode #(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] SLOT0  = '0,
    parameter logic [ADDR_W-1:0] SLOT1  = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              idx
);
    always_comb begin
        hit = 1'b0;
        idx = 1'b0;
        if (addr == SLOT0) begin
            hit = 1'b1;
        end else if (addr == SLOT1) begin
            hit = 1'b1;
            idx = 1'b1;
        end
    end
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile #(
    parameter int DATA_W = 8,
    parameter int NREG   = 2,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_we,
    input  logic [IDX_W-1:0]            host_idx,
    input  logic [DATA_W-1:0]           host_wdata,
    input  logic                        dsp_we,
    input  logic [IDX_W-1:0]            dsp_idx,
    input  logic [DATA_W-1:0]           dsp_wdata,
    output logic [NREG-1:0][DATA_W-1:0] regs
);
    generate
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs[r] <= '0;
                end else if (dsp_we && dsp_idx == IDX_W'(r)) begin
                    regs[r] <= dsp_wdata;
                end else if (host_we && host_idx == IDX_W'(r)) begin
                    regs[r] <= host_wdata;
                end
            end
        end
    endgenerate

    AST_DSP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_we && host_we && dsp_idx == host_idx) |=> regs[$past(dsp_idx)] == $past(dsp_wdata)); // R8

    AST_REGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!dsp_we && !host_we) |=> $stable(regs)); // R11
endmodule

// File: rtl/mbx_host_fsm.sv
module mbx_host_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_sync,
    input  logic wr_sync,
    input  logic dsp_wr_busy,
    output logic commit_we,
    output logic capture,
    output logic host_wait_n
);
    host_st_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= H_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            H_IDLE: begin
                if (wr_sync)                   nxt = H_WDONE;
                else if (rd_sync && dsp_wr_busy) nxt = H_RWAIT;
                else if (rd_sync)              nxt = H_RSERVE;
            end
            H_WDONE:  if (!wr_sync)     nxt = H_IDLE;
            H_RWAIT:  if (!dsp_wr_busy) nxt = H_RSERVE;
            H_RSERVE: if (!rd_sync)     nxt = H_IDLE;
            default:  nxt = H_IDLE;
        endcase
    end

    always_comb begin
        commit_we   = (state == H_IDLE) && wr_sync;
        capture     = (nxt == H_RSERVE) && (state != H_RSERVE);
        host_wait_n = (state != H_RWAIT);
    end

    AST_WAIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_wait_n) |-> $past(dsp_wr_busy)); // R6

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wait_n && dsp_wr_busy) |=> !host_wait_n); // R6

    AST_WAIT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_wait_n) |-> $past(rd_sync)); // R7
endmodule

// File: rtl/io_mailbox.sv
module io_mailbox #(
    parameter int                 DATA_W      = 8,
    parameter int                 HADDR_W     = 4,
    parameter int                 DADDR_W     = 8,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [HADDR_W-1:0] HOST_ASLOT  = 4'h6,
    parameter logic [HADDR_W-1:0] HOST_DSLOT  = 4'h7,
    parameter logic [DADDR_W-1:0] DSP_ASLOT   = 8'h40,
    parameter logic [DADDR_W-1:0] DSP_DSLOT   = 8'h41
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_reg_n,
    input  logic               host_ce1_n,
    input  logic               host_ce2_n,
    input  logic               host_iord_n,
    input  logic               host_iowr_n,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_rd_oe,
    output logic               host_wait_n,
    input  logic               dsp_ms_n,
    input  logic               dsp_rd_n,
    input  logic               dsp_wr_n,
    input  logic [DADDR_W-1:0] dsp_addr,
    input  logic [DATA_W-1:0]  dsp_wdata,
    output logic [DATA_W-1:0]  dsp_rdata,
    output logic               dsp_rd_oe
);
    localparam int NREG = 2;

    logic host_cyc, rd_req, wr_req, rd_sync, wr_sync;
    logic dsp_wr_busy;
    logic host_hit, host_idx, dsp_hit, dsp_idx;
    logic commit_we, capture;
    logic [NREG-1:0][DATA_W-1:0] regs;
    logic [DATA_W-1:0] host_rdata_q;

    assign host_cyc    = !host_reg_n && !host_ce1_n && host_ce2_n;
    assign rd_req      = host_cyc && !host_iord_n;
    assign wr_req      = host_cyc && !host_iowr_n;
    assign dsp_wr_busy = !dsp_ms_n && !dsp_wr_n;

    mbx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({rd_req, wr_req}),
        .q_sync  ({rd_sync, wr_sync})
    );

    mbx_decode #(.ADDR_W(HADDR_W), .SLOT0(HOST_ASLOT), .SLOT1(HOST_DSLOT)) u_hdec (
        .addr (host_addr),
        .hit  (host_hit),
        .idx  (host_idx)
    );

    mbx_decode #(.ADDR_W(DADDR_W), .SLOT0(DSP_ASLOT), .SLOT1(DSP_DSLOT)) u_ddec (
        .addr (dsp_addr),
        .hit  (dsp_hit),
        .idx  (dsp_idx)
    );

    mbx_host_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_sync     (rd_sync),
        .wr_sync     (wr_sync),
        .dsp_wr_busy (dsp_wr_busy),
        .commit_we   (commit_we),
        .capture     (capture),
        .host_wait_n (host_wait_n)
    );

    mbx_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (commit_we && host_hit),
        .host_idx   (host_idx),
        .host_wdata (host_wdata),
        .dsp_we     (dsp_wr_busy && dsp_hit),
        .dsp_idx    (dsp_idx),
        .dsp_wdata  (dsp_wdata),
        .regs       (regs)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       host_rdata_q <= '0;
        else if (capture) host_rdata_q <= host_hit ? regs[host_idx] : '0;
    end

    assign host_rd_oe = rd_req;
    assign host_rdata = host_rd_oe ? host_rdata_q : '0;
    assign dsp_rd_oe  = !dsp_ms_n && !dsp_rd_n;
    assign dsp_rdata  = (dsp_rd_oe && dsp_hit) ? regs[dsp_idx] : '0;

    AST_HOST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_oe |-> host_rdata == '0); // R5

    AST_WAIT_NO_OE_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wait_n |-> rd_sync); // R6
endmodule

// File: tb/tb_io_mailbox.sv
`timescale 1ns/1ps
module tb_io_mailbox;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_reg_n = 1'b1, host_ce1_n = 1'b1, host_ce2_n = 1'b1;
    logic       host_iord_n = 1'b1, host_iowr_n = 1'b1;
    logic [3:0] host_addr = 4'hF;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       host_rd_oe, host_wait_n;
    logic       dsp_ms_n = 1'b1, dsp_rd_n = 1'b1, dsp_wr_n = 1'b1;
    logic [7:0] dsp_addr = 8'hFF;
    logic [7:0] dsp_wdata = 8'h00;
    logic [7:0] dsp_rdata;
    logic       dsp_rd_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [3:0] HA = 4'h6, HD = 4'h7;
    localparam logic [7:0] DA = 8'h40, DD = 8'h41;

    always #2 clk = ~clk;

    io_mailbox dut (
        .clk(clk), .rst_n(rst_n),
        .host_reg_n(host_reg_n), .host_ce1_n(host_ce1_n), .host_ce2_n(host_ce2_n),
        .host_iord_n(host_iord_n), .host_iowr_n(host_iowr_n),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rd_oe(host_rd_oe), .host_wait_n(host_wait_n),
        .dsp_ms_n(dsp_ms_n), .dsp_rd_n(dsp_rd_n), .dsp_wr_n(dsp_wr_n),
        .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata),
        .dsp_rdata(dsp_rdata), .dsp_rd_oe(dsp_rd_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_idle();
        host_reg_n = 1'b1; host_ce1_n = 1'b1; host_ce2_n = 1'b1;
        host_iord_n = 1'b1; host_iowr_n = 1'b1; host_addr = 4'hF;
    endtask

    task automatic dsp_idle();
        dsp_ms_n = 1'b1; dsp_rd_n = 1'b1; dsp_wr_n = 1'b1; dsp_addr = 8'hFF;
    endtask

    task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d;
        host_reg_n = 1'b0; host_ce1_n = 1'b0; host_ce2_n = 1'b1; host_iowr_n = 1'b0;
        repeat (6) @(negedge clk);
        host_idle();
        repeat (4) @(negedge clk);
    endtask

    task automatic host_rd(input logic [3:0] a, output logic [7:0] d, output bit waited);
        @(negedge clk);
        host_addr = a;
        host_reg_n = 1'b0; host_ce1_n = 1'b0; host_ce2_n = 1'b1; host_iord_n = 1'b0;
        waited = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!host_wait_n) waited = 1'b1;
        end
        d = host_rdata;
        host_idle();
        repeat (4) @(negedge clk);
    endtask

    task automatic dsp_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        dsp_addr = a; dsp_wdata = d; dsp_ms_n = 1'b0; dsp_wr_n = 1'b0;
        repeat (10) @(negedge clk);
        dsp_idle();
        @(negedge clk);
    endtask

    task automatic dsp_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        dsp_addr = a; dsp_ms_n = 1'b0; dsp_rd_n = 1'b0;
        #1;
        d = dsp_rdata;
        @(negedge clk);
        dsp_idle();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk(host_wait_n === 1'b1, "R1 wait_n", int'(host_wait_n), 1);
        chk(host_rd_oe === 1'b0 && dsp_rd_oe === 1'b0, "R1 oe", int'({host_rd_oe, dsp_rd_oe}), 0);
        dsp_rd(DA, v); chk(v === 8'h00, "R1 addr slot", v, 0);
        dsp_rd(DD, v); chk(v === 8'h00, "R1 data slot", v, 0);
    endtask

    task automatic t_host_to_dsp();
        logic [7:0] v;
        host_wr(HA, 8'hA5);
        host_wr(HD, 8'h3C);
        dsp_rd(DA, v); chk(v === 8'hA5, "R3 addr slot", v, 8'hA5);
        dsp_rd(DD, v); chk(v === 8'h3C, "R3 data slot", v, 8'h3C);
    endtask

    task automatic t_dsp_to_host();
        logic [7:0] v; bit w;
        dsp_wr(DA, 8'h96);
        dsp_wr(DD, 8'h69);
        host_rd(HA, v, w); chk(v === 8'h96, "R4 addr slot", v, 8'h96);
        chk(!w, "R7 no wait on plain read", int'(w), 0);
        host_rd(HD, v, w); chk(v === 8'h69, "R4 data slot", v, 8'h69);
        chk(!w, "R7 no wait on plain read", int'(w), 0);
    endtask

    task automatic t_bad_cycles();
        logic [7:0] v;
        @(negedge clk);
        host_addr = HD; host_wdata = 8'hEE;
        host_reg_n = 1'b0; host_ce1_n = 1'b0; host_ce2_n = 1'b0; host_iowr_n = 1'b0;
        repeat (6) @(negedge clk);
        host_idle();
        @(negedge clk);
        host_addr = HD; host_wdata = 8'hEE;
        host_reg_n = 1'b1; host_ce1_n = 1'b0; host_ce2_n = 1'b1; host_iowr_n = 1'b0;
        repeat (6) @(negedge clk);
        host_idle();
        repeat (4) @(negedge clk);
        dsp_rd(DD, v); chk(v === 8'h69, "R2 malformed host write ignored", v, 8'h69);
    endtask

    task automatic t_stray_addr();
        logic [7:0] v;
        host_wr(4'h2, 8'h77);
        dsp_wr(8'h55, 8'h88);
        dsp_rd(DA, v); chk(v === 8'h96, "R11 addr slot untouched", v, 8'h96);
        dsp_rd(DD, v); chk(v === 8'h69, "R11 data slot untouched", v, 8'h69);
        dsp_rd(8'h55, v); chk(v === 8'h00, "R11 stray read zero", v, 0);
    endtask

    task automatic t_oe();
        @(negedge clk);
        #1;
        chk(host_rd_oe === 1'b0 && host_rdata === 8'h00, "R5 host idle quiet", int'(host_rdata), 0);
        chk(dsp_rd_oe === 1'b0 && dsp_rdata === 8'h00, "R5 dsp idle quiet", int'(dsp_rdata), 0);
        dsp_addr = DA; dsp_ms_n = 1'b0; dsp_rd_n = 1'b0;
        #1;
        chk(dsp_rd_oe === 1'b1, "R5 dsp oe on read", int'(dsp_rd_oe), 1);
        dsp_idle();
        host_addr = HA; host_reg_n = 1'b0; host_ce1_n = 1'b0; host_ce2_n = 1'b1; host_iord_n = 1'b0;
        #1;
        chk(host_rd_oe === 1'b1, "R5 host oe on read", int'(host_rd_oe), 1);
        host_idle();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_wait();
        @(negedge clk);
        dsp_addr = DA; dsp_wdata = 8'h5A; dsp_ms_n = 1'b0; dsp_wr_n = 1'b0;
        @(negedge clk);
        host_addr = HA; host_reg_n = 1'b0; host_ce1_n = 1'b0; host_ce2_n = 1'b1; host_iord_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(host_wait_n === 1'b0, "R6 wait asserted", int'(host_wait_n), 0);
        repeat (10) @(negedge clk);
        chk(host_wait_n === 1'b0, "R6 wait held", int'(host_wait_n), 0);
        dsp_idle();
        repeat (2) @(negedge clk);
        chk(host_wait_n === 1'b1, "R6 wait released", int'(host_wait_n), 1);
        chk(host_rdata === 8'h5A, "R6 host sees DSP value", host_rdata, 8'h5A);
        host_idle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_collide(input bit same);
        logic [7:0] v;
        @(negedge clk);
        dsp_addr = same ? DD : DA; dsp_wdata = 8'h33; dsp_ms_n = 1'b0; dsp_wr_n = 1'b0;
        host_addr = HD; host_wdata = 8'hCC;
        host_reg_n = 1'b0; host_ce1_n = 1'b0; host_ce2_n = 1'b1; host_iowr_n = 1'b0;
        repeat (8) @(negedge clk);
        dsp_idle(); host_idle();
        repeat (4) @(negedge clk);
        if (same) begin
            dsp_rd(DD, v); chk(v === 8'h33, "R8 DSP wins", v, 8'h33);
        end else begin
            dsp_rd(DA, v); chk(v === 8'h33, "R9 DSP write lands", v, 8'h33);
            dsp_rd(DD, v); chk(v === 8'hCC, "R9 host write lands", v, 8'hCC);
        end
    endtask

    task automatic t_latency();
        @(negedge clk);
        dsp_addr = DA; dsp_ms_n = 1'b0; dsp_rd_n = 1'b0;
        host_addr = HA; host_wdata = 8'hE1;
        host_reg_n = 1'b0; host_ce1_n = 1'b0; host_ce2_n = 1'b1; host_iowr_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(dsp_rdata !== 8'hE1, "R10 not after two edges", dsp_rdata, 0);
        @(negedge clk);
        chk(dsp_rdata === 8'hE1, "R10 after three edges", dsp_rdata, 8'hE1);
        host_idle(); dsp_idle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_host_to_dsp();
        t_dsp_to_host();
        t_bad_cycles();
        t_stray_addr();
        t_oe();
        t_wait();
        t_collide(1'b1);
        t_collide(1'b0);
        t_latency();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule